// File: doc/BRIEF.md
# Dataflow Frame Mapping Write Decoder

This block sits on the global load bus of an 8 by 8 grid of processing elements. Each element holds a local store of activation frames. The block accepts one frame-mapping request per cycle and turns it into one write enable for each element. It also passes on the local frame index and the frame contents that every store receives.

Each request carries its own mapping mode, so the mode may differ from one frame to the next:

- **Single-target mode** writes one frame in one element, chosen by a column index and a row index.
- **Broadcast mode** writes the same frame at the same local index in every element in the same cycle.
- **Masked mode** writes every element whose column bit is set in a column mask and whose row bit is set in a row mask.

Requests enter on a valid/ready handshake. Ready is the Load-mode level and nothing else. While the system is out of Load mode, ready is low, so a pending request waits with valid held high and is not consumed. While in Load mode, every valid request is taken in the cycle it is presented, so there is never back-pressure. The outputs are registered. The stores are assumed to take a write in every cycle, so the outputs carry no handshake.

Top module: `graph_map_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `wr_en` is all zero and `map_err` is 0.
- R2: `req_ready` equals `load_mode`. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both 1.
- R3: Mode code 2'b00 (single-target): one cycle after acceptance, exactly bit `req_y*8 + req_x` of `wr_en` is 1. Element (x,y) always maps to bit y*8+x.
- R4: Mode code 2'b01 (broadcast): one cycle after acceptance, all 64 bits of `wr_en` are 1. The X and Y parts of the request are ignored.
- R5: Mode code 2'b10 (masked): one cycle after acceptance, bit y*8+x of `wr_en` is 1 exactly when `req_col_mask[x]` and `req_row_mask[y]` are both 1. An empty mask in either direction gives no enable.
- R6: In the cycle where any `wr_en` bit is 1, `wr_z` and `wr_data` hold the Z part and the frame data of the accepted request.
- R7: `wr_en` is all zero in any cycle that does not follow an accepted request. This covers both `req_valid` low and `load_mode` low. Each accepted request drives its enables for one cycle only.
- R8: Mode code 2'b11 is illegal. One cycle after such a request is accepted, `wr_en` is all zero and `map_err` is 1 for that single cycle. `map_err` is 0 in every other cycle.
- R9: Requests accepted in consecutive cycles may each use a different mode. Each one is decoded under its own mode, with no gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_mode | input | 1 | System is in Load mode |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle (equals load_mode) |
| req_mode | input | 2 | 00 single, 01 broadcast, 10 masked, 11 illegal |
| req_x | input | 3 | Column index of the target element |
| req_y | input | 3 | Row index of the target element |
| req_z | input | 10 | Frame index inside each element's store |
| req_col_mask | input | 8 | Column select mask, bit x for column x |
| req_row_mask | input | 8 | Row select mask, bit y for row y |
| req_data | input | 144 | Frame contents |
| wr_en | output | 64 | Per-element write enables, bit y*8+x |
| wr_z | output | 10 | Frame index for all stores |
| wr_data | output | 144 | Frame contents for all stores |
| map_err | output | 1 | One-cycle pulse on an accepted illegal mode |

## Verification
The hardest situation to reach is a back-to-back run in which the mode changes on every cycle. Such a run exposes any decode that lags the request by a cycle. The stimulus forces it with a directed burst that cycles through all four codes with no idle cycle between them. It also includes a request held valid while `load_mode` is low and then released, so that a stalled request is seen to be taken exactly once. A behavioural per-element model in the bench predicts every enable bit on every clock. Sweeps cover every single-target position and structured and random mask pairs, including empty masks.

// File: rtl/gmd_pkg.sv
package gmd_pkg;
  typedef enum logic [1:0] {
    MAP_SINGLE  = 2'b00,
    MAP_BCAST   = 2'b01,
    MAP_MASKED  = 2'b10,
    MAP_ILLEGAL = 2'b11
  } map_mode_e;
endpackage

// File: rtl/gmd_axis_sel.sv
// Per-axis selector: one select line per column (or per row) of the grid.
module gmd_axis_sel
  import gmd_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  map_mode_e      mode,
  input  logic [IW-1:0]  idx,
  input  logic [N-1:0]   mask,
  output logic [N-1:0]   sel
);
  for (genvar i = 0; i < N; i++) begin : g_line
    always_comb begin
      unique case (mode)
        MAP_SINGLE: sel[i] = (idx == IW'(i));
        MAP_BCAST:  sel[i] = 1'b1;
        MAP_MASKED: sel[i] = mask[i];
        default:    sel[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gmd_enable_grid.sv
// Crossing of row and column selects: element (x,y) maps to bit y*COLS+x.
module gmd_enable_grid #(
  parameter int COLS = 8,
  parameter int ROWS = 8,
  localparam int NPE = COLS * ROWS
) (
  input  logic            fire,
  input  logic [COLS-1:0] col_sel,
  input  logic [ROWS-1:0] row_sel,
  output logic [NPE-1:0]  en
);
  for (genvar y = 0; y < ROWS; y++) begin : g_row
    for (genvar x = 0; x < COLS; x++) begin : g_col
      assign en[y*COLS + x] = fire & row_sel[y] & col_sel[x];
    end
  end
endmodule

// File: rtl/graph_map_decoder.sv
module graph_map_decoder
  import gmd_pkg::*;
#(
  parameter int COLS = 8,
  parameter int ROWS = 8,
  parameter int ZW   = 10,
  parameter int DW   = 144,
  localparam int XW  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int YW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int NPE = COLS * ROWS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_mode,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_mode,
  input  logic [XW-1:0]   req_x,
  input  logic [YW-1:0]   req_y,
  input  logic [ZW-1:0]   req_z,
  input  logic [COLS-1:0] req_col_mask,
  input  logic [ROWS-1:0] req_row_mask,
  input  logic [DW-1:0]   req_data,
  output logic [NPE-1:0]  wr_en,
  output logic [ZW-1:0]   wr_z,
  output logic [DW-1:0]   wr_data,
  output logic            map_err
);
  map_mode_e       mode;
  logic            take;
  logic            legal;
  logic [COLS-1:0] col_sel;
  logic [ROWS-1:0] row_sel;
  logic [NPE-1:0]  en_next;

  assign mode      = map_mode_e'(req_mode);
  assign req_ready = load_mode;
  assign take      = req_valid & req_ready;
  assign legal     = (mode != MAP_ILLEGAL);

  gmd_axis_sel #(.N(COLS)) u_col (
    .mode(mode), .idx(req_x), .mask(req_col_mask), .sel(col_sel)
  );
  gmd_axis_sel #(.N(ROWS)) u_row (
    .mode(mode), .idx(req_y), .mask(req_row_mask), .sel(row_sel)
  );
  gmd_enable_grid #(.COLS(COLS), .ROWS(ROWS)) u_grid (
    .fire(take & legal), .col_sel(col_sel), .row_sel(row_sel), .en(en_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= '0;
      map_err <= 1'b0;
    end else begin
      wr_en   <= en_next;
      map_err <= take & ~legal;
    end
  end

  // Address and data only move on an accepted legal request.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_z    <= '0;
      wr_data <= '0;
    end else if (take && legal) begin
      wr_z    <= req_z;
      wr_data <= req_data;
    end
  end

  // R7
  en_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en != '0) |-> $past(req_valid && load_mode));
  // R3
  single_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && load_mode && req_mode == 2'b00) |=> ($countones(wr_en) == 1));
  // R4
  bcast_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && load_mode && req_mode == 2'b01) |=> (&wr_en));
  // R5
  mask_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && load_mode && req_mode == 2'b10) |=>
      ($countones(wr_en) ==
       $countones($past(req_col_mask)) * $countones($past(req_row_mask))));
  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && load_mode && req_mode == 2'b11) |=> (map_err && wr_en == '0));
  // R6
  z_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en != '0) |-> (wr_z == $past(req_z)));
endmodule

// File: tb/tb_graph_map_decoder.sv
module tb_graph_map_decoder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_mode = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_mode = 2'b00;
  logic [2:0]   req_x = '0;
  logic [2:0]   req_y = '0;
  logic [9:0]   req_z = '0;
  logic [7:0]   req_col_mask = '0;
  logic [7:0]   req_row_mask = '0;
  logic [143:0] req_data = '0;
  logic [63:0]  wr_en;
  logic [9:0]   wr_z;
  logic [143:0] wr_data;
  logic         map_err;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  string tag_force = "";

  logic [63:0]  exp_en = '0;
  logic [9:0]   exp_z  = '0;
  logic [143:0] exp_data = '0;
  logic         exp_err = 1'b0;
  string        exp_tag = "R1";

  always #5 clk = ~clk;

  graph_map_decoder dut (
    .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_mode(req_mode), .req_x(req_x), .req_y(req_y),
    .req_z(req_z), .req_col_mask(req_col_mask), .req_row_mask(req_row_mask),
    .req_data(req_data), .wr_en(wr_en), .wr_z(wr_z), .wr_data(wr_data),
    .map_err(map_err)
  );

  // Behavioural reference: per-element decision from the requirement text.
  always @(posedge clk) begin
    logic [63:0] e;
    bit acc;
    e = '0;
    acc = rst_n && req_valid && load_mode;
    if (!rst_n) begin
      exp_tag = "R1";
    end else if (!acc) begin
      exp_tag = "R7";
    end else begin
      for (int y = 0; y < 8; y++)
        for (int x = 0; x < 8; x++) begin
          case (req_mode)
            2'b00: e[y*8+x] = (x == int'(req_x)) && (y == int'(req_y));
            2'b01: e[y*8+x] = 1'b1;
            2'b10: e[y*8+x] = req_col_mask[x] && req_row_mask[y];
            default: e[y*8+x] = 1'b0;
          endcase
        end
      case (req_mode)
        2'b00: exp_tag = "R3";
        2'b01: exp_tag = "R4";
        2'b10: exp_tag = "R5";
        default: exp_tag = "R8";
      endcase
      if (tag_force != "") exp_tag = tag_force;
      if (req_mode != 2'b11) begin
        exp_z = req_z;
        exp_data = req_data;
      end
    end
    exp_en  = e;
    exp_err = acc && (req_mode == 2'b11);
  end

  task automatic check_now();
    n_tests++;
    if (wr_en !== exp_en) begin
      n_fail++;
      $display("FAIL %s wr_en actual=%h expected=%h", exp_tag, wr_en, exp_en);
    end
    n_tests++;
    if (map_err !== exp_err) begin
      n_fail++;
      $display("FAIL R8 map_err actual=%b expected=%b", map_err, exp_err);
    end
    n_tests++;
    if (req_ready !== load_mode) begin
      n_fail++;
      $display("FAIL R2 req_ready actual=%b expected=%b", req_ready, load_mode);
    end
    if (exp_en != '0) begin
      n_tests++;
      if (wr_z !== exp_z || wr_data !== exp_data) begin
        n_fail++;
        $display("FAIL R6 z/data actual=%h/%h expected=%h/%h",
                 wr_z, wr_data, exp_z, exp_data);
      end
    end
  endtask

  task automatic send(input bit v, input bit l, input logic [1:0] m,
                      input int x, input int y, input logic [7:0] cm,
                      input logic [7:0] rm);
    req_valid = v;
    load_mode = l;
    req_mode  = m;
    req_x     = 3'(x);
    req_y     = 3'(y);
    req_z     = 10'($urandom);
    req_col_mask = cm;
    req_row_mask = rm;
    req_data  = {$urandom, $urandom, $urandom, $urandom, 16'($urandom)};
    @(negedge clk);
    check_now();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs quiet even with a request offered
    req_valid = 1'b1;
    load_mode = 1'b1;
    req_mode  = 2'b01;
    repeat (4) begin
      @(negedge clk);
      check_now();
    end
    rst_n = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    check_now();

    // R3: every single-target position
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 8; x++)
        send(1, 1, 2'b00, x, y, 8'h00, 8'h00);
    // R4: broadcast ignores X/Y
    for (int k = 0; k < 4; k++) send(1, 1, 2'b01, k, 7 - k, 8'h5A, 8'hA5);
    // R5: structured masks, including empty ones
    send(1, 1, 2'b10, 0, 0, 8'h00, 8'hFF);
    send(1, 1, 2'b10, 0, 0, 8'hFF, 8'h00);
    send(1, 1, 2'b10, 0, 0, 8'hFF, 8'hFF);
    send(1, 1, 2'b10, 0, 0, 8'h81, 8'h18);
    send(1, 1, 2'b10, 0, 0, 8'h01, 8'h80);
    for (int k = 0; k < 8; k++) send(1, 1, 2'b10, 0, 0, 8'(1 << k), 8'(~(1 << k)));
    // R8: illegal code, then idle cycle
    send(1, 1, 2'b11, 3, 3, 8'hFF, 8'hFF);
    send(0, 1, 2'b00, 0, 0, 8'h00, 8'h00);
    // R7: valid low, and valid high outside Load mode (stalled request)
    send(0, 1, 2'b01, 0, 0, 8'h00, 8'h00);
    send(1, 0, 2'b01, 0, 0, 8'h00, 8'h00);
    send(1, 0, 2'b01, 0, 0, 8'h00, 8'h00);
    send(1, 1, 2'b01, 0, 0, 8'h00, 8'h00);
    send(0, 1, 2'b01, 0, 0, 8'h00, 8'h00);
    // R9: mode changes on every back-to-back request
    tag_force = "R9";
    for (int k = 0; k < 16; k++)
      send(1, 1, 2'(k), k, k + 3, 8'($urandom), 8'($urandom));
    tag_force = "";
    // mixed random traffic
    for (int k = 0; k < 600; k++)
      send(($urandom % 4) != 0, ($urandom % 5) != 0, 2'($urandom),
           int'($urandom % 8), int'($urandom % 8), 8'($urandom), 8'($urandom));
    send(0, 1, 2'b00, 0, 0, 8'h00, 8'h00);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule